// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer, modelled at the RF input clock rate. It pairs a dual-modulus prescaler with two down-counters. The swallow counter (A) sets how many prescaler cycles use the larger modulus P+1 in each output period. The main counter (B) sets the total number of prescaler cycles in the period. The input clock is therefore divided by N = P*B + A. The lower modulus P is 8 or 32 and is picked by a select input. The divided output is a single-cycle pulse that a phase detector downstream uses as its feedback edge.

The A and B inputs come from an external latch. They are sampled only when the counters reload: at the terminal count of each period and while the divider is held. A hold input stands for a counter-reset or power-down condition. It parks the divider at its load state, and counting starts again from there once the hold is released. Programmed values that are not legal are clamped to the nearest legal setting and reported on an error output.

Top module: `pswallow_div`

## Requirements
- R1: With `sel_hi` = 0 (P = 8), consecutive `fp` pulses are exactly N = 8*B + A input cycles apart.
- R2: With `sel_hi` = 1 (P = 32), consecutive `fp` pulses are exactly N = 32*B + A input cycles apart, with A using all 5 bits.
- R3: `fp` is high for exactly one input cycle per output period.
- R4: While `hold` is 1, `fp` stays 0 and the counters sit at their load state. Counting resumes from the load state at the first rising edge with `hold` = 0, and the first `fp` is seen in the cycle that follows the N-th such edge.
- R5: A change to `a_val` or `b_val` in the middle of a period does not alter that period's length. It takes effect from the next reload.
- R6: With `sel_hi` = 0, only `a_val[2:0]` is used and `a_val[4:3]` has no effect.
- R7: A B value below 3 is treated as 3 and sets `cfg_err` to 1.
- R8: An A value (after the masking of R6) that is greater than the B value is treated as equal to the clamped B and sets `cfg_err` to 1.
- R9: `cfg_err` is 0 whenever B >= 3 and A <= B.
- R10: The corners A = 0 (all prescaler cycles use P) and A = B (all cycles use P+1) divide by P*B and (P+1)*B respectively.
- R11: After reset is released and before the first period ends, `fp` is 0. `sel_hi` is changed only while `hold` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RF-rate input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Keeps the divider at its load state while 1 |
| sel_hi | input | 1 | Lower modulus select: 0 means P = 8, 1 means P = 32 |
| a_val | input | 5 | Swallow count A from the external latch |
| b_val | input | 13 | Main count B from the external latch |
| fp | output | 1 | One-cycle divided output pulse |
| cfg_err | output | 1 | 1 when A or B was outside its legal range and has been clamped |

## Verification
For both moduli the divider is swept over every B from 0 to a small upper bound, paired with A values that run past B and, for P = 8, past the 3-bit field. Each interval is compared with P*B+A worked out from the clamped values. This sweep covers A = 0, A = B and the clamp paths, and it shows whether the extra prescaler cycle is counted once per swallowed cycle and not once per period. A mid-period change of A and B separates sampling at reload from sampling at once. A long hold inside a running period shows whether the divider really parks and then restarts a full period, rather than carrying on with a partial count.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  // Modulus requested for the next prescaler cycle.
  typedef enum logic [0:0] {
    PS_BASE  = 1'b0,  // divide by P
    PS_EXTRA = 1'b1   // divide by P+1 (swallow cycle)
  } ps_mode_e;

endpackage

// File: rtl/pswallow_cfg.sv
module pswallow_cfg #(
  parameter int P_LO  = 8,
  parameter int P_HI  = 32,
  parameter int B_W   = 13,
  parameter int B_MIN = 3
) (
  input  logic                        sel_hi,
  input  logic [$clog2(P_HI)-1:0]     a_val,
  input  logic [B_W-1:0]              b_val,
  output logic [$clog2(P_HI)-1:0]     a_eff,
  output logic [B_W-1:0]              b_eff,
  output logic                        cfg_err
);
  localparam int A_W    = $clog2(P_HI);
  localparam int A_LO_W = $clog2(P_LO);
  localparam logic [A_W-1:0] LO_MASK = A_W'((1 << A_LO_W) - 1);

  logic [A_W-1:0] a_m;
  logic           b_low;
  logic           a_over;

  always_comb begin
    a_m     = sel_hi ? a_val : (a_val & LO_MASK);
    b_low   = (b_val < B_W'(B_MIN));
    b_eff   = b_low ? B_W'(B_MIN) : b_val;
    a_over  = (B_W'(a_m) > b_eff);
    a_eff   = a_over ? b_eff[A_W-1:0] : a_m;
    cfg_err = b_low | a_over;
  end

endmodule

// File: rtl/pswallow_presc.sv
module pswallow_presc
  import pswallow_pkg::*;
#(
  parameter int P_LO = 8,
  parameter int P_HI = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     sel_hi,
  input  ps_mode_e next_mode,
  output logic     tick
);
  localparam int PC_W = $clog2(P_HI + 1);
  localparam logic [PC_W-1:0] RL_LO = PC_W'(P_LO - 1);
  localparam logic [PC_W-1:0] RL_HI = PC_W'(P_HI - 1);

  logic [PC_W-1:0] pc_q, pc_d, reload;

  always_comb begin
    reload = (sel_hi ? RL_HI : RL_LO) + PC_W'(next_mode == PS_EXTRA);
    tick   = (pc_q == '0);
    if (load || tick) pc_d = reload;
    else              pc_d = pc_q - PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R2: prescaler count never exceeds the larger modulus minus one plus one
  p_pc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_W'(P_HI));

  // R1: a prescaler cycle is never shorter than P_LO, so ticks never touch
  p_tick_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> !tick);

endmodule

// File: rtl/pswallow_ctr.sv
module pswallow_ctr
  import pswallow_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int B_W   = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           tick,
  input  logic [A_W-1:0] a_eff,
  input  logic [B_W-1:0] b_eff,
  output ps_mode_e       next_mode,
  output logic           fp
);
  logic [A_W-1:0] sc_q, sc_d;
  logic [B_W-1:0] bc_q, bc_d;
  logic           fp_q, fp_d;
  logic           term;

  always_comb begin
    term = tick && (bc_q == B_W'(1));
    sc_d = sc_q;
    bc_d = bc_q;
    fp_d = 1'b0;
    if (load) begin
      sc_d = a_eff;
      bc_d = b_eff;
    end else if (term) begin
      sc_d = a_eff;
      bc_d = b_eff;
      fp_d = 1'b1;
    end else if (tick) begin
      bc_d = bc_q - B_W'(1);
      sc_d = (sc_q != '0) ? sc_q - A_W'(1) : '0;
    end
    next_mode = (sc_d != '0) ? PS_EXTRA : PS_BASE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
      bc_q <= B_W'(1);
      fp_q <= 1'b0;
    end else begin
      sc_q <= sc_d;
      bc_q <= bc_d;
      fp_q <= fp_d;
    end
  end

  assign fp = fp_q;

  // R3: the output pulse lasts a single cycle
  p_fp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q |=> !fp_q);

  // R4: no pulse follows a held cycle
  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !fp_q);

  // R8: swallow count never exceeds remaining main count
  p_swallow_le_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
    B_W'(sc_q) <= bc_q);

  // R1: main counter never wraps through zero
  p_main_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bc_q != '0);

  // R5: counters only move on a prescaler tick or a load
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> ($stable(bc_q) && $stable(sc_q)));

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int P_LO  = 8,
  parameter int P_HI  = 32,
  parameter int B_W   = 13,
  parameter int B_MIN = 3,
  localparam int A_W  = $clog2(P_HI)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           sel_hi,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           fp,
  output logic           cfg_err
);
  logic [A_W-1:0] a_eff;
  logic [B_W-1:0] b_eff;
  logic           init_q, init_d;
  logic           load;
  logic           tick;
  ps_mode_e       next_mode;

  // One load cycle after reset places the counters at their load state.
  always_comb begin
    init_d = 1'b0;
    load   = hold | init_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b1;
    else        init_q <= init_d;
  end

  pswallow_cfg #(
    .P_LO(P_LO), .P_HI(P_HI), .B_W(B_W), .B_MIN(B_MIN)
  ) u_cfg (
    .sel_hi (sel_hi),
    .a_val  (a_val),
    .b_val  (b_val),
    .a_eff  (a_eff),
    .b_eff  (b_eff),
    .cfg_err(cfg_err)
  );

  pswallow_presc #(
    .P_LO(P_LO), .P_HI(P_HI)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .sel_hi   (sel_hi),
    .next_mode(next_mode),
    .tick     (tick)
  );

  pswallow_ctr #(
    .A_W(A_W), .B_W(B_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .tick     (tick),
    .a_eff    (a_eff),
    .b_eff    (b_eff),
    .next_mode(next_mode),
    .fp       (fp)
  );

  // R7 and R8: clamped values handed to the counters are always legal
  p_cfg_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_eff >= B_W'(B_MIN)) && (B_W'(a_eff) <= b_eff));

  // R11: no pulse in the cycle after reset release
  p_no_early_fp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> !fp);

endmodule

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 3000;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hold;
  logic        sel_hi;
  logic [4:0]  a_val;
  logic [12:0] b_val;
  logic        fp;
  logic        cfg_err;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pswallow_div u_dut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel_hi(sel_hi),
    .a_val(a_val), .b_val(b_val), .fp(fp), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_CYCLES) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_n(input bit hi, input int a, input int b);
    int eb = (b < 3) ? 3 : b;
    int am = hi ? a : (a % 8);
    int ea = (am > eb) ? eb : am;
    return (hi ? 32 : 8) * eb + ea;
  endfunction

  function automatic bit exp_err(input bit hi, input int a, input int b);
    int am = hi ? a : (a % 8);
    int eb = (b < 3) ? 3 : b;
    return (b < 3) || (am > eb);
  endfunction

  task automatic count_to_fp(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fp && n < LIMIT);
  endtask

  task automatic setup(input bit hi, input int a, input int b);
    hold   = 1'b1;
    sel_hi = hi;
    a_val  = 5'(a);
    b_val  = 13'(b);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cfg(input bit hi, input int a, input int b, input string req);
    int n;
    int e = exp_n(hi, a, b);
    setup(hi, a, b);
    chk(cfg_err == exp_err(hi, a, b), {req, " cfg_err (R7 R8 R9)"},
        int'(cfg_err), int'(exp_err(hi, a, b)));
    hold = 1'b0;
    count_to_fp(n);
    chk(n == e, {req, " first period after release (R4)"}, n, e);
    @(negedge clk);
    chk(!fp, {req, " pulse width (R3)"}, int'(fp), 0);
    count_to_fp(n);
    chk(n + 1 == e, {req, " steady period"}, n + 1, e);
  endtask

  initial begin
    int n;
    int hits;
    rst_n  = 1'b0;
    hold   = 1'b1;
    sel_hi = 1'b0;
    a_val  = '0;
    b_val  = 13'd3;
    repeat (3) @(negedge clk);
    chk(fp == 1'b0, "R11 fp during reset", int'(fp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fp == 1'b0, "R11 fp after reset release", int'(fp), 0);

    // R1, R6, R7, R8, R10: sweep of P = 8 including ignored upper A bits
    for (int b = 0; b <= 12; b++)
      for (int a = 0; a <= 15; a++)
        run_cfg(1'b0, a, b, "R1 P8 sweep");

    // R2, R7, R8, R10: sweep of P = 32
    for (int b = 0; b <= 5; b++)
      for (int a = 0; a <= 7; a++)
        run_cfg(1'b1, a, b, "R2 P32 sweep");
    run_cfg(1'b1, 31, 40, "R2 P32 full A field");

    // R10 corners named explicitly
    run_cfg(1'b0, 0, 7, "R10 A=0");
    run_cfg(1'b0, 7, 7, "R10 A=B");

    // R6: upper A bits ignored at P = 8
    run_cfg(1'b0, 24 + 5, 9, "R6 upper bits set");

    // R5: mid-period change applies only from the next reload
    setup(1'b0, 2, 5);
    hold = 1'b0;
    repeat (20) @(negedge clk);
    a_val = 5'd5;
    b_val = 13'd9;
    count_to_fp(n);
    chk(n + 20 == exp_n(1'b0, 2, 5), "R5 current period keeps old N", n + 20, exp_n(1'b0, 2, 5));
    count_to_fp(n);
    chk(n == exp_n(1'b0, 5, 9), "R5 next period uses new N", n, exp_n(1'b0, 5, 9));

    // R4: hold inside a running period parks the divider
    repeat (30) @(negedge clk);
    hold = 1'b1;
    hits = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (fp) hits++;
    end
    chk(hits == 0, "R4 no pulse while held", hits, 0);
    hold = 1'b0;
    count_to_fp(n);
    chk(n == exp_n(1'b0, 5, 9), "R4 full period after release", n, exp_n(1'b0, 5, 9));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule